// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-interrupt state of a multi-processor interrupt distributor: an enable bit, a pending mask with one bit per processor, the sampled input level, a 1-of-N handling-model bit, an edge/level trigger bit, a priority byte and a processor-target mask. It turns changes on external request lines into pending bits, and it raises software interrupts for a chosen set of processors. It exports the global enable and the enable, pending and priority vectors to per-processor arbiters. Those arbiters, and the acknowledge and completion logic, sit outside this block.

Software reaches the bank through a byte-wide access port. Each access carries the index of the requesting processor. Bit-per-interrupt windows are kept apart for setting and clearing enable and pending, so a write never needs a read-modify-write. The first 32 interrupt IDs carry fixed values that the write path enforces. An access the bank does not implement changes no state, reads as zero and sets a sticky error flag.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the global enable is 0, IDs 0 to 15 are enabled and edge-triggered, every other enable bit is 0, no pending bit is set and the error flag is clear.
- R2: At offset 0x000, bit 0 is the global enable (read/write, shown on `dist_en`). Offset 0x004 is read-only and returns the processor count minus one in bits 7:5 and the number of 32-ID groups minus one in bits 4:0. Offsets 0x001 to 0x007 otherwise read 0, and writes to 0x001 to 0x003 are ignored.
- R3: In the windows at 0x100 (set-enable) and 0x180 (clear-enable), bit i of byte k stands for ID 8k+i, and reads of either window return the enable bits. Writing a 1 sets or clears the enable bit. For IDs below 16 a set write acts as all ones and a clear write acts as zero, so those IDs stay enabled.
- R4: When an enable bit is set on a level-sensitive ID whose input is high, that ID's pending bits are also set for its target mask.
- R5: A 1 written to the set-pending window at 0x200 sets pending for the ID's target mask. A 1 written to the clear-pending window at 0x280 clears pending for every processor. Reads of either window return the requester's own pending bit for IDs below 32, and the OR over all processors for higher IDs.
- R6: The priority window at 0x400 holds one read/write byte per ID, exported on `irq_prio` at bits 8*ID+7 to 8*ID.
- R7: The target window at 0x800 holds one byte per ID. IDs below 29 store 0. IDs 29 to 31 store all processors and read back as the requester's own bit, that is, 1 shifted left by the processor index. Higher IDs store the written byte masked to the processor count.
- R8: In the configuration window at 0xC00, byte k covers IDs 4k to 4k+3. For ID 4k+j, bit 2j selects the 1-of-N model and bit 2j+1 selects edge triggering. Writes covering IDs below 32 are ORed with 0xAA.
- R9: External line n drives ID n+32, and only a change of level takes effect. A rising level sets pending for the target mask if the ID is edge-triggered or enabled. A falling level clears only the stored level.
- R10: A word write (`acc_word`=1) to 0xF00 sets pending for the ID in bits 9:0. Bits 25:24 select the targets: 0 means the list in bits 16 and up, 1 means the requester only, 2 means every processor except the requester, 3 means all processors.
- R11: In the window at 0xFE0, the aligned byte at 0xFE0+4j reads 0xA0+j and unaligned bytes read 0. The active window at 0x300 reads 0 for implemented IDs.
- R12: The following accesses are illegal: a write to the active window, an ID at or beyond NUM_IRQ, an undecoded offset, a word access anywhere other than a write to 0xF00, and a write to the identification window. An illegal access changes no state, reads 0 and sets `acc_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 32-bit access (software-interrupt write) |
| acc_cpu | input | CW | Index of the requesting processor |
| acc_addr | input | 12 | Byte offset |
| acc_wdata | input | 32 | Write data (bits 7:0 for byte writes) |
| acc_rdata | output | 8 | Read data, combinational |
| ext_irq | input | NUM_IRQ-32 | External request lines |
| dist_en | output | 1 | Global enable |
| irq_en | output | NUM_IRQ | Per-ID enable |
| irq_pend | output | NUM_IRQ*NUM_CPU | Pending, NUM_CPU bits per ID |
| irq_prio | output | NUM_IRQ*8 | Priority byte per ID |
| acc_err | output | 1 | Sticky illegal-access flag |

## Verification
The bench targets the forced behaviour of the low IDs. A design that let a clear-enable write through would drop IDs 0 to 15, and one that skipped the 0xAA OR would read back level-sensitive low IDs. It drives the input lines past enable changes. A design that set pending on a falling input or on a steady level would show pending after a clear, and one that ignored the level on set-enable would miss the pending bit from R4. Each software-interrupt filter runs from a known requester, which exposes a swapped requester mask. The bench also checks that an out-of-range enable write leaves `irq_en` untouched while it raises the flag.

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int NEXT = NUM_IRQ - 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_en,
  input  logic                       acc_wr,
  input  logic                       acc_word,
  input  logic [CW-1:0]              acc_cpu,
  input  logic [11:0]                acc_addr,
  input  logic [31:0]                acc_wdata,
  output logic [7:0]                 acc_rdata,
  input  logic [NEXT-1:0]            ext_irq,
  output logic                       dist_en,
  output logic [NUM_IRQ-1:0]         irq_en,
  output logic [NUM_IRQ*NUM_CPU-1:0] irq_pend,
  output logic [NUM_IRQ*8-1:0]       irq_prio,
  output logic                       acc_err
);
  localparam logic [NUM_CPU-1:0] ALL = '1;
  localparam logic [NUM_CPU-1:0] ONE = 1;
  localparam logic [7:0] TYPE_REG = {3'(NUM_CPU - 1), 5'(NUM_IRQ / 32 - 1)};

  logic               gen_q, gen_n, err_q;
  logic [NUM_IRQ-1:0] en_q, en_n, trig_q, trig_n, model_q, model_n, lvl_q, lvl_n;
  logic [NUM_CPU-1:0] pend_q [NUM_IRQ];
  logic [NUM_CPU-1:0] pend_n [NUM_IRQ];
  logic [NUM_CPU-1:0] tgt_q  [NUM_IRQ];
  logic [NUM_CPU-1:0] tgt_n  [NUM_IRQ];
  logic [7:0]         prio_q [NUM_IRQ];
  logic [7:0]         prio_n [NUM_IRQ];

  wire [11:0] a = acc_addr;
  wire w_ctl = a[11:8] == 4'h0;
  wire w_se  = a[11:7] == 5'h02;
  wire w_ce  = a[11:7] == 5'h03;
  wire w_sp  = a[11:7] == 5'h04;
  wire w_cp  = a[11:7] == 5'h05;
  wire w_act = a[11:8] == 4'h3;
  wire w_pri = a[11:10] == 2'b01;
  wire w_tgt = a[11:10] == 2'b10;
  wire w_cfg = a[11:10] == 2'b11 && a[9:8] != 2'b11;
  wire w_id  = a[11:5] == 7'h7F;
  wire [NUM_CPU-1:0] me = ONE << acc_cpu;
  wire unused_wdata = ^acc_wdata;

  int k7, k8, kb, sid;
  assign k7  = int'(a[6:0]);
  assign k8  = int'(a[7:0]);
  assign kb  = int'(a[9:0]);
  assign sid = int'(acc_wdata[9:0]);

  logic bad;
  always_comb begin
    bad = 1'b1;
    if (acc_word)                       bad = !(acc_wr && a == 12'hF00 && sid < NUM_IRQ);
    else if (w_ctl)                     bad = acc_wr ? (a[7:2] != 0) : (a[7:3] != 0);
    else if (w_se || w_ce || w_sp || w_cp) bad = k7 * 8 >= NUM_IRQ;
    else if (w_act)                     bad = acc_wr || k8 * 8 >= NUM_IRQ;
    else if (w_pri || w_tgt)            bad = kb >= NUM_IRQ;
    else if (w_cfg)                     bad = kb * 4 >= NUM_IRQ;
    else if (w_id)                      bad = acc_wr;
    bad = bad && acc_en;
  end

  wire wb  = acc_en && acc_wr && !acc_word && !bad;
  wire sgi = acc_en && acc_word && !bad;

  logic [NUM_CPU-1:0] sgi_mask;
  always_comb
    case (acc_wdata[25:24])
      2'd0:    sgi_mask = acc_wdata[16 +: NUM_CPU];
      2'd1:    sgi_mask = me;
      2'd2:    sgi_mask = ALL ^ me;
      default: sgi_mask = ALL;
    endcase

  always_comb begin
    gen_n = gen_q; en_n = en_q; trig_n = trig_q; model_n = model_q; lvl_n = lvl_q;
    pend_n = pend_q; tgt_n = tgt_q; prio_n = prio_q;
    for (int e = 0; e < NEXT; e++)
      if (ext_irq[e] != lvl_q[e+32]) begin
        lvl_n[e+32] = ext_irq[e];
        if (ext_irq[e] && (trig_q[e+32] || en_q[e+32])) pend_n[e+32] = pend_n[e+32] | tgt_q[e+32];
      end
    if (wb && w_ctl && a[1:0] == 2'b00 && a[7:2] == 0) gen_n = acc_wdata[0];
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (wb && w_se && (i / 8) == k7 && (i < 16 || acc_wdata[i%8])) begin
        en_n[i] = 1'b1;
        if (lvl_n[i] && !trig_q[i]) pend_n[i] = pend_n[i] | tgt_q[i];
      end
      if (wb && w_ce && (i / 8) == k7 && i >= 16 && acc_wdata[i%8]) en_n[i] = 1'b0;
      if (wb && w_sp && (i / 8) == k7 && acc_wdata[i%8]) pend_n[i] = pend_n[i] | tgt_q[i];
      if (wb && w_cp && (i / 8) == k7 && acc_wdata[i%8]) pend_n[i] = '0;
      if (wb && w_pri && i == kb) prio_n[i] = acc_wdata[7:0];
      if (wb && w_tgt && i == kb) tgt_n[i] = (i < 29) ? '0 : (i < 32) ? ALL : acc_wdata[NUM_CPU-1:0];
      if (wb && w_cfg && (i / 4) == kb) begin
        model_n[i] = acc_wdata[2*(i%4)];
        trig_n[i]  = acc_wdata[2*(i%4)+1] || i < 32;
      end
      if (sgi && i == sid) pend_n[i] = pend_n[i] | sgi_mask;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_en && !acc_wr && !bad) begin
      if (w_ctl) acc_rdata = (a[2:0] == 3'd0) ? {7'b0, gen_q} : (a[2:0] == 3'd4) ? TYPE_REG : 8'h00;
      else if (w_id) acc_rdata = (a[1:0] != 2'b00) ? 8'h00 : (8'hA0 | 8'(a[4:2]));
      else
        for (int i = 0; i < NUM_IRQ; i++) begin
          if ((w_se || w_ce) && (i / 8) == k7) acc_rdata[i%8] = en_q[i];
          if ((w_sp || w_cp) && (i / 8) == k7) acc_rdata[i%8] = (i < 32) ? pend_q[i][acc_cpu] : |pend_q[i];
          if (w_pri && i == kb) acc_rdata = prio_q[i];
          if (w_tgt && i == kb) acc_rdata = (i >= 29 && i <= 31) ? 8'(me) : 8'(tgt_q[i]);
          if (w_cfg && (i / 4) == kb) begin
            acc_rdata[2*(i%4)]   = model_q[i];
            acc_rdata[2*(i%4)+1] = trig_q[i];
          end
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gen_q <= 1'b0; err_q <= 1'b0; model_q <= '0; lvl_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        en_q[i] <= i < 16; trig_q[i] <= i < 16;
        pend_q[i] <= '0; tgt_q[i] <= '0; prio_q[i] <= '0;
      end
    end else begin
      gen_q <= gen_n; err_q <= err_q | bad;
      en_q <= en_n; trig_q <= trig_n; model_q <= model_n; lvl_q <= lvl_n;
      pend_q <= pend_n; tgt_q <= tgt_n; prio_q <= prio_n;
    end

  assign dist_en = gen_q;
  assign irq_en  = en_q;
  assign acc_err = err_q;
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_out
    assign irq_pend[g*NUM_CPU +: NUM_CPU] = pend_q[g];
    assign irq_prio[g*8 +: 8] = prio_q[g];
  end

  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !acc_word && acc_addr == 12'h000) |=> dist_en == $past(acc_wdata[0]));
  a_r3_low_ids_on: assert property (@(posedge clk) disable iff (!rst_n) &irq_en[15:0]);
  a_r9_fall_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_irq[0] && lvl_q[32] && !(acc_en && acc_wr)) |=> $stable(pend_q[32]));
  a_r12_flag_set: assert property (@(posedge clk) disable iff (!rst_n) (acc_en && bad) |=> acc_err);
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n) acc_err |=> acc_err);
endmodule

// File: tb/irq_dist_regs_bench.sv
module irq_dist_regs_bench;
  localparam int CLK_P = 10;
  localparam int N = 64;
  localparam int C = 2;

  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0, acc_word = 0;
  logic [0:0] acc_cpu = 0;
  logic [11:0] acc_addr = 0;
  logic [31:0] acc_wdata = 0;
  logic [7:0] acc_rdata;
  logic [N-33:0] ext_irq = '0;
  logic dist_en, acc_err;
  logic [N-1:0] irq_en;
  logic [N*C-1:0] irq_pend;
  logic [N*8-1:0] irq_prio;
  int errors = 0, checks = 0;
  bit done = 0;

  irq_dist_regs u_irq_dist_regs (.clk, .rst_n, .acc_en, .acc_wr, .acc_word, .acc_cpu, .acc_addr,
    .acc_wdata, .acc_rdata, .ext_irq, .dist_en, .irq_en, .irq_pend, .irq_prio, .acc_err);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr8(input logic [11:0] ad, input logic [7:0] d, input int c = 0);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_word = 0; acc_addr = ad; acc_wdata = {24'b0, d}; acc_cpu = c[0:0];
    @(negedge clk); acc_en = 0; acc_wr = 0;
  endtask

  task automatic wr32(input logic [31:0] d, input int c);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_word = 1; acc_addr = 12'hF00; acc_wdata = d; acc_cpu = c[0:0];
    @(negedge clk); acc_en = 0; acc_wr = 0; acc_word = 0;
  endtask

  task automatic rd8(input logic [11:0] ad, input int c, input logic [7:0] exp, input string tag);
    @(negedge clk); acc_en = 1; acc_wr = 0; acc_word = 0; acc_addr = ad; acc_cpu = c[0:0];
    #1 chk(tag, acc_rdata, exp);
    @(negedge clk); acc_en = 0;
  endtask

  task automatic ext_set(input int line, input logic v);
    @(negedge clk); ext_irq[line] = v;
    @(negedge clk);
  endtask

  function automatic logic [1:0] pend_of(input int id);
    return irq_pend[id*C +: C];
  endfunction

  task automatic t_reset();
    rd8(12'h000, 0, 8'h00, "R1 global enable off");
    rd8(12'h100, 0, 8'hFF, "R1 ids 0-7 enabled");
    rd8(12'h101, 0, 8'hFF, "R1 ids 8-15 enabled");
    rd8(12'h102, 0, 8'h00, "R1 ids 16-23 disabled");
    rd8(12'hC00, 0, 8'hAA, "R1 low ids edge");
    chk("R1 no pending", irq_pend, '0);
    chk("R1 error clear", acc_err, 0);
  endtask

  task automatic t_ctrl();
    rd8(12'h004, 0, 8'h21, "R2 type register");
    wr8(12'h000, 8'h01);
    chk("R2 dist_en set", dist_en, 1);
    rd8(12'h000, 1, 8'h01, "R2 readback");
    wr8(12'h002, 8'hFF);
    rd8(12'h002, 0, 8'h00, "R2 offset 2 ignored");
    chk("R2 offset 2 no error", acc_err, 0);
  endtask

  task automatic t_enable();
    wr8(12'h104, 8'h05);
    rd8(12'h104, 0, 8'h05, "R3 set enable 32,34");
    chk("R3 irq_en port", irq_en[39:32], 8'h05);
    wr8(12'h184, 8'h01);
    rd8(12'h184, 0, 8'h04, "R3 clear enable 32");
    wr8(12'h180, 8'hFF);
    wr8(12'h181, 8'hFF);
    chk("R3 low ids forced on", irq_en[15:0], 16'hFFFF);
    wr8(12'h102, 8'h03);
    wr8(12'h182, 8'h01);
    rd8(12'h102, 0, 8'h02, "R3 clear id 16");
  endtask

  task automatic t_target();
    wr8(12'h828, 8'hFF);
    rd8(12'h828, 0, 8'h03, "R7 masked to cpu count");
    wr8(12'h805, 8'h03);
    rd8(12'h805, 0, 8'h00, "R7 low id stores 0");
    rd8(12'h81E, 1, 8'h02, "R7 id30 reads cpu1 bit");
    rd8(12'h81D, 0, 8'h01, "R7 id29 reads cpu0 bit");
  endtask

  task automatic t_prio();
    wr8(12'h428, 8'h80);
    rd8(12'h428, 0, 8'h80, "R6 priority readback");
    chk("R6 priority port", irq_prio[40*8 +: 8], 8'h80);
  endtask

  task automatic t_pend();
    wr8(12'h205, 8'h01);
    chk("R5 set pending to targets", pend_of(40), 2'b11);
    rd8(12'h285, 1, 8'h01, "R5 pending read id 40");
    wr8(12'h285, 8'h01);
    chk("R5 clear pending", pend_of(40), 2'b00);
  endtask

  task automatic t_cfg();
    wr8(12'hC0A, 8'h06);
    rd8(12'hC0A, 0, 8'h06, "R8 config readback");
    wr8(12'hC00, 8'h00);
    rd8(12'hC00, 0, 8'hAA, "R8 low ids forced edge");
    wr8(12'hC04, 8'h55);
    rd8(12'hC04, 0, 8'hFF, "R8 model kept, edge forced");
  endtask

  task automatic t_ext();
    wr8(12'h82C, 8'h01);
    ext_set(12, 1);
    chk("R9 rise on disabled level id", pend_of(44), 2'b00);
    wr8(12'h105, 8'h10);
    chk("R4 enable with level high", pend_of(44), 2'b01);
    wr8(12'h285, 8'h10);
    ext_set(12, 0);
    chk("R9 fall sets nothing", pend_of(44), 2'b00);
    ext_set(12, 1);
    chk("R9 rise on enabled id", pend_of(44), 2'b01);
    ext_set(12, 0);
    chk("R9 fall keeps pending", pend_of(44), 2'b01);
    wr8(12'h285, 8'h10);
    ext_set(8, 1);
    chk("R9 rise on edge id", pend_of(40), 2'b11);
    wr8(12'h285, 8'h01);
    ext_set(8, 1);
    chk("R9 steady level no effect", pend_of(40), 2'b00);
    ext_set(8, 0);
  endtask

  task automatic t_sgi();
    wr32(32'h0002_0005, 0);
    chk("R10 filter 0 list", pend_of(5), 2'b10);
    rd8(12'h200, 0, 8'h00, "R5 low id read own bit cpu0");
    rd8(12'h200, 1, 8'h20, "R5 low id read own bit cpu1");
    wr8(12'h280, 8'hFF);
    wr32(32'h0100_0006, 0);
    chk("R10 filter 1 requester", pend_of(6), 2'b01);
    wr32(32'h0200_0007, 0);
    chk("R10 filter 2 others", pend_of(7), 2'b10);
    wr32(32'h0300_0008, 1);
    chk("R10 filter 3 all", pend_of(8), 2'b11);
    wr8(12'h280, 8'hFF);
    wr8(12'h281, 8'hFF);
    chk("R5 clear all low", irq_pend[16*C-1:0], '0);
  endtask

  task automatic t_id();
    rd8(12'hFE0, 0, 8'hA0, "R11 id byte 0");
    rd8(12'hFE4, 0, 8'hA1, "R11 id byte 1");
    rd8(12'hFE1, 0, 8'h00, "R11 unaligned id");
    rd8(12'h300, 0, 8'h00, "R11 active reads 0");
    chk("R12 no error yet", acc_err, 0);
  endtask

  task automatic t_err();
    logic [N-1:0] snap;
    snap = irq_en;
    wr8(12'h108, 8'hFF);
    chk("R12 beyond count flags", acc_err, 1);
    chk("R12 beyond count no change", irq_en, snap);
    rd8(12'h440, 0, 8'h00, "R12 bad read zero");
    wr8(12'h300, 8'h01);
    rd8(12'h000, 0, 8'h01, "R12 good read after error");
    chk("R12 error sticky", acc_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ctrl(); t_enable(); t_target(); t_prio(); t_pend();
    t_cfg(); t_ext(); t_sgi(); t_id(); t_err();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule